// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a bank of general-purpose input lines and turns activity on them into interrupt requests. Every line has its own enable bit and its own trigger selection. Three per-line configuration vectors choose the trigger: edge or level, the polarity, and a mode that fires on both edges. A detected event sets a sticky status bit. Software clears a status bit by writing a one to it. A single interrupt output is raised while any status bit is set and also enabled.

The inputs arrive already synchronised to `clk`. Edges are found by comparing each line with the value it had at the previous clock edge. A small register port gives write and combinational read access to the five word registers. When a design needs more lines than one bank holds, it places several instances side by side. Line n then belongs to instance n/32, at bit n mod 32.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the enable, rise/high-select (sel0) and level-select (sel1) registers read 0, the both-edges register (sel2) reads all ones, status reads 0 and `irq_o` is low.
- R2: The registers are decoded from `reg_addr[4:2]`: enable at 0x00, sel0 at 0x04, sel1 at 0x08, sel2 at 0x0C, status at 0x10. A write stores the full word into enable or a select register and reads back unchanged. Any other address reads 0, and a write to it changes no register.
- R3: A line with sel1=0 and sel2=0 is edge-sensitive. With sel0=1 a 0-to-1 change between two consecutive clock samples sets its status bit, and with sel0=0 a 1-to-0 change does. The status bit becomes visible in the cycle after the edge at which the new value was sampled. No edge is detected at the first clock edge after reset.
- R4: A line with sel1=0 and sel2=1 sets its status bit on any change between consecutive samples, whatever the value of sel0.
- R5: A line with sel1=1 is level-sensitive, and sel2 is ignored. With sel0=1 the status bit is set at every clock edge where the input is 1; with sel0=0 it is set where the input is 0.
- R6: Status bits are sticky. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A status bit is only ever set by an event.
- R7: While a level-sensitive line stays at its active level, clearing its status bit does not leave the bit at 0. After the line leaves its active level, a clear does leave it at 0.
- R8: When a clearing write and a new event on the same bit fall at the same clock edge, the bit stays set.
- R9: `irq_o` is high exactly when some bit is set in both status and enable. A status bit still records events while its enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | Synchronised input lines of the bank |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| irq_o | output | 1 | Bank interrupt request |

## Verification
Two things can land on the same status bit at the same clock edge: a write-one-to-clear from software and a fresh event detected on the line. The bench provokes this by issuing a clear of all status bits in the very cycle that it changes the input pattern. In that cycle many of the 32 lines, across all eight trigger combinations, see edges or active levels. It judges the outcome against a cycle model in which the new event overrides the clear. The same collision is exercised continuously on level-sensitive lines held at their active level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int BANK_AW = 5;

    typedef enum logic [2:0] {
        SEL_ENABLE = 3'd0,
        SEL_RISEHI = 3'd1,
        SEL_LEVEL  = 3'd2,
        SEL_BOTH   = 3'd3,
        SEL_STATUS = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg #(
    parameter int W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  gpio_irq_pkg::reg_sel_e sel,
    input  logic [W-1:0]           wdata,
    output logic [W-1:0]           en_o,
    output logic [W-1:0]           sel0_o,
    output logic [W-1:0]           sel1_o,
    output logic [W-1:0]           sel2_o
);
    import gpio_irq_pkg::*;

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] s0;
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } cfg_t;

    localparam cfg_t CFG_RST = '{en: '0, s0: '0, s1: '0, s2: {W{1'b1}}};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (sel)
                SEL_ENABLE: cfg_d.en = wdata;
                SEL_RISEHI: cfg_d.s0 = wdata;
                SEL_LEVEL:  cfg_d.s1 = wdata;
                SEL_BOTH:   cfg_d.s2 = wdata;
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign en_o   = cfg_q.en;
    assign sel0_o = cfg_q.s0;
    assign sel1_o = cfg_q.s1;
    assign sel2_o = cfg_q.s2;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] sel0_i,
    input  logic [W-1:0] sel1_i,
    input  logic [W-1:0] sel2_i,
    output logic [W-1:0] evt_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic         primed;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d        = det_q;
        det_d.prev   = pin_i;
        det_d.primed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        logic rise, fall, edge_hit, level_hit;
        always_comb begin
            rise      = pin_i[i] & ~det_q.prev[i];
            fall      = ~pin_i[i] & det_q.prev[i];
            edge_hit  = det_q.primed & (sel2_i[i] ? (rise | fall)
                                                  : (sel0_i[i] ? rise : fall));
            level_hit = ~(pin_i[i] ^ sel0_i[i]);
            evt_o[i]  = sel1_i[i] ? level_hit : edge_hit;
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] sts_o
);
    logic [W-1:0] sts_d, sts_q;

    always_comb begin
        sts_d = (sts_q & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [W-1:0]                     pin_i,
    input  logic                             reg_we,
    input  logic [gpio_irq_pkg::BANK_AW-1:0] reg_addr,
    input  logic [W-1:0]                     reg_wdata,
    output logic [W-1:0]                     reg_rdata,
    output logic                             irq_o
);
    import gpio_irq_pkg::*;

    reg_sel_e     sel_w;
    logic         mapped_w;
    logic [W-1:0] en_w, s0_w, s1_w, s2_w, evt_w, sts_w, clr_w;

    always_comb begin
        sel_w    = reg_sel_e'(reg_addr[4:2]);
        mapped_w = (reg_addr[4:2] <= 3'd4);
        clr_w    = (reg_we && sel_w == SEL_STATUS) ? reg_wdata : '0;
    end

    gpio_irq_cfg #(.W(W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we && mapped_w), .sel(sel_w),
        .wdata(reg_wdata), .en_o(en_w), .sel0_o(s0_w), .sel1_o(s1_w), .sel2_o(s2_w)
    );

    gpio_irq_detect #(.W(W)) u_det (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sel0_i(s0_w),
        .sel1_i(s1_w), .sel2_i(s2_w), .evt_o(evt_w)
    );

    gpio_irq_status #(.W(W)) u_sts (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_w), .clr_i(clr_w), .sts_o(sts_w)
    );

    always_comb begin
        case (sel_w)
            SEL_ENABLE: reg_rdata = en_w;
            SEL_RISEHI: reg_rdata = s0_w;
            SEL_LEVEL:  reg_rdata = s1_w;
            SEL_BOTH:   reg_rdata = s2_w;
            SEL_STATUS: reg_rdata = sts_w;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_o = |(sts_w & en_w);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_we,
    input logic [4:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic         irq_o,
    input logic [W-1:0] evt,
    input logic [W-1:0] sts
);
    // R8: an event at an edge leaves its status bit set, clear or not
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((sts & $past(evt)) == $past(evt)));

    // R6: a written one clears a bit that had no event in that cycle
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[4:2] == 3'd4) |=>
            ((sts & $past(reg_wdata) & ~$past(evt)) == '0));

    // R6: without a clearing write no status bit falls
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr[4:2] == 3'd4) |=> ((~sts & $past(sts)) == '0));

    // R6: a status bit rises only after an event
    p_set_by_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || !reg_we) |=> ((sts & ~$past(sts) & ~$past(evt)) == '0));

    // R9: a full disable drops the request
    p_mask_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[4:2] == 3'd0 && reg_wdata == '0) |=> !irq_o);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_o(irq_o), .evt(evt_w), .sts(sts_w)
);

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
    localparam int W = 32;
    localparam logic [4:0] A_EN = 5'h00, A_S0 = 5'h04, A_S1 = 5'h08,
                           A_S2 = 5'h0C, A_ST = 5'h10, A_BAD = 5'h14;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, irq_o;
    logic [W-1:0] pin = '0, reg_wdata = '0, reg_rdata;
    logic [4:0] reg_addr = A_ST;
    int tests = 0, fails = 0;
    bit done = 0;

    logic [W-1:0] m_en = '0, m_s0 = '0, m_s1 = '0, m_s2 = '1, m_sts = '0, m_prev = '0;
    logic m_primed = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_bank #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [W-1:0] model_evt(input logic [W-1:0] p);
        logic [W-1:0] e;
        for (int i = 0; i < W; i++) begin
            logic r, f;
            r = p[i] & ~m_prev[i];
            f = ~p[i] & m_prev[i];
            if (m_s1[i])      e[i] = (p[i] == m_s0[i]);
            else if (!m_primed) e[i] = 1'b0;
            else if (m_s2[i]) e[i] = r | f;
            else              e[i] = m_s0[i] ? r : f;
        end
        return e;
    endfunction

    function automatic string mode_tag(input logic [W-1:0] diff);
        for (int i = 0; i < W; i++)
            if (diff[i]) return m_s1[i] ? "R5" : (m_s2[i] ? "R4" : "R3");
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one clock: drive at negedge, model at posedge, check status and irq after it
    task automatic cyc(input logic [W-1:0] p, input logic we, input logic [4:0] a,
                       input logic [W-1:0] wd, input string tag);
        logic [W-1:0] ev, clr, d_before;
        @(negedge clk);
        pin = p; reg_we = we; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        ev  = model_evt(p);
        clr = (we && a[4:2] == 3'd4) ? wd : '0;
        m_sts = (m_sts & ~clr) | ev;
        if (we) case (a[4:2])
            3'd0: m_en = wd;
            3'd1: m_s0 = wd;
            3'd2: m_s1 = wd;
            3'd3: m_s2 = wd;
            default: ;
        endcase
        m_prev = p; m_primed = 1'b1;
        #1; reg_we = 1'b0; reg_addr = A_ST; #1;
        d_before = reg_rdata ^ m_sts;
        check(tag.len() ? tag : mode_tag(d_before), reg_rdata, m_sts);
        check("R9 irq", {31'd0, irq_o}, {31'd0, |(m_sts & m_en)});
    endtask

    task automatic rd(input logic [4:0] a, input logic [W-1:0] exp, input string tag);
        cyc(pin, 1'b0, A_ST, '0, "");
        reg_addr = a; #1;
        check(tag, reg_rdata, exp);
    endtask

    logic [W-1:0] t0v, t1v, t2v;

    initial begin
        #2_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog R1: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset values
        rd(A_EN, '0, "R1 enable");
        rd(A_S0, '0, "R1 sel0");
        rd(A_S1, '0, "R1 sel1");
        rd(A_S2, '1, "R1 sel2");
        rd(A_ST, '0, "R1 status");
        check("R1 irq", {31'd0, irq_o}, 32'd0);

        // R2 register map and readback
        cyc(pin, 1'b1, A_S0, 32'h1234_5678, "");
        cyc(pin, 1'b1, A_S1, 32'h0, "");
        cyc(pin, 1'b1, A_EN, 32'hA5A5_0F0F, "");
        rd(A_S0, 32'h1234_5678, "R2 sel0");
        rd(A_EN, 32'hA5A5_0F0F, "R2 enable");
        cyc(pin, 1'b1, A_BAD, 32'hDEAD_BEEF, "");
        rd(A_BAD, '0, "R2 unmapped");
        rd(A_S0, 32'h1234_5678, "R2 sel0 after unmapped write");
        rd(A_S2, '1, "R2 sel2 after unmapped write");
        rd(A_EN, 32'hA5A5_0F0F, "R2 enable after unmapped write");

        // all eight mode combinations spread over the bits, enable off
        for (int i = 0; i < W; i++) begin
            t0v[i] = i[0]; t1v[i] = i[1]; t2v[i] = i[2];
        end
        cyc(pin, 1'b1, A_EN, '0, "");
        cyc(pin, 1'b1, A_S0, t0v, "");
        cyc(pin, 1'b1, A_S1, t1v, "");
        cyc(pin, 1'b1, A_S2, t2v, "");
        rd(A_S1, t1v, "R2 sel1");
        cyc(pin, 1'b1, A_ST, '1, "");
        // R3 R4 R5 sweep; every fourth step collides a clear with events (R8)
        for (int k = 0; k < 64; k++) begin
            logic [W-1:0] pat;
            pat = (k == 0) ? '0 : (k == 1) ? '1 : W'(k * 32'h9E37_79B9) ^ W'(k << 7);
            if (k % 4 == 3) cyc(pat, 1'b1, A_ST, '1, "R8 clear vs event");
            else            cyc(pat, 1'b0, A_ST, '0, "");
        end
        // R9 status recorded while disabled, then various enables
        cyc(32'h0, 1'b0, A_ST, '0, "");
        cyc(32'hFFFF_FFFF, 1'b0, A_ST, '0, "R9 record while disabled");
        check("R9 irq low with enable 0", {31'd0, irq_o}, 32'd0);
        cyc(pin, 1'b1, A_EN, 32'h0000_00F0, "");
        cyc(pin, 1'b1, A_EN, 32'h8000_0000, "");
        cyc(pin, 1'b1, A_EN, 32'h0000_0001, "");
        cyc(pin, 1'b1, A_EN, '0, "");

        // R6 zero write no effect, partial clear
        cyc(32'hF0F0_1234, 1'b0, A_ST, '0, "");
        cyc(pin, 1'b1, A_ST, '0, "R6 write zeros");
        cyc(pin, 1'b1, A_ST, 32'h0000_FFFF, "R6 partial clear");

        // R7 level-high on all lines
        cyc(pin, 1'b1, A_S1, '1, "");
        cyc(pin, 1'b1, A_S0, '1, "");
        cyc(32'hFFFF_FFFF, 1'b0, A_ST, '0, "");
        cyc(pin, 1'b1, A_ST, '1, "R7 clear while active");
        check("R7 still set", reg_rdata, '1);
        cyc(32'h0, 1'b0, A_ST, '0, "");
        cyc(pin, 1'b1, A_ST, '1, "R7 clear after inactive");
        check("R7 cleared", reg_rdata, '0);
        // R5 level-low
        cyc(pin, 1'b1, A_S0, '0, "");
        cyc(32'h0000_FFFF, 1'b1, A_ST, '1, "R5 level low");
        check("R5 low half set", reg_rdata, 32'hFFFF_0000);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule